// File: doc/BRIEF.md
# Per-Processor Local Interrupt Register Bank

This block keeps one small set of interrupt registers for every processor in a cluster. Each set holds a control word, a local pending vector, a local enable mask, a route word for the compare interrupt, a remote-select index and a 32-bit compare value. An identity register reports which set is being accessed. A single request port carries the requester's processor index, a register address and write data. The top address bit picks one of two windows. The near window always lands in the requester's own set. The far window lands in the set named by the requester's remote-select register, so any processor can reach the registers of any other.

A per-processor compare-match strobe from an external timer sets that processor's compare-pending bit. The compare interrupt is driven onto one of the processor's interrupt lines, chosen by its route word. It is gated by the compare bit of the local mask and by the route enable flag. Each line is the OR of this compare contribution and a routed shared-source level that arrives from outside. Writing a new compare value acknowledges the compare interrupt.

Top module: `proc_local_bank`

## Requirements
- R1: An access with address bit 4 = 0 targets the bank of `req_id`. An access with address bit 4 = 1 targets the bank whose index is held in the remote-select register of `req_id`. Address bits 3:0 select the register: 0 control, 1 pending, 2 mask, 3 mask-clear, 4 mask-set, 5 route, 6 remote-select, 7 identity, 8 compare value, 9 compare upper half.
- R2: A write to remote-select takes effect only when the full 32-bit data is below NUM_PROC. Any other value leaves the register unchanged.
- R3: A read of the identity register returns the index of the targeted bank.
- R4: The mask is 6 bits wide, and its compare enable is bit 1. A mask-set write ORs data bits 5:0 into it. A mask-clear write clears each mask bit whose data bit is 1. The mask register itself cannot be written, and data bits above 5 are dropped.
- R5: A write of the compare value stores it and clears pending bit 1. A read of the compare upper half returns 0.
- R6: A compare-match strobe sets pending bit 1 of its processor. If the strobe arrives in the same cycle as a compare-value write to that bank, the bit ends up set.
- R7: Interrupt line p of processor i (`irq_out[i*NPIN+p]`) is high when the shared input at the same index is high. It is also high when all of these hold: that processor's pending bit 1 is set, mask bit 1 is set, the route flag (bit 31) is set and the route pin field equals p. Outputs reflect register state one clock after the causing edge.
- R8: The route word has an enable flag in bit 31 and a pin number in bits 5:0. A route write whose bits 5:0 exceed NPIN-1 is ignored. A legal write stores bit 31 and the pin number.
- R9: After reset every bank holds control 0, pending 0, mask 0x32, route 0x8000_0000, compare value 0xFFFF_FFFF and remote-select 0.
- R10: Writes to the control register have no effect, and it reads 0. Register addresses 10 to 15 read 0 in both windows.
- R11: A read request returns its data on `rsp_rdata` with `rsp_valid` high in the next cycle. `rsp_valid` is low after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | PID_W | Index of the requesting processor |
| req_addr | input | 5 | Bit 4 window select, bits 3:0 register |
| req_wdata | input | 32 | Write data |
| cmp_hit | input | NUM_PROC | Compare-match strobe per processor |
| shared_irq | input | NUM_PROC*NPIN | Routed shared-source level per processor line |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NUM_PROC*NPIN | Interrupt lines per processor |

## Verification
The compare-match strobe and a compare-value write aimed at the same bank can land on the same clock edge, one setting and the other clearing the pending bit. The bench raises the strobe during the write cycle. It then judges the result by reading the pending register and the mapped interrupt line, both of which must show the interrupt still pending. A shared source and the compare interrupt can also drive the same line together. The bench shows that acknowledging the compare keeps the line high while the shared level remains, and that the line drops once both are gone.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int REG_W    = 4;
  localparam int MASK_W   = 6;
  localparam int CMP_BIT  = 1;
  localparam int RT_FIELD = 6;
  localparam int RT_FLAG  = 31;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  localparam logic [REG_W-1:0] RG_CTRL  = 4'd0;
  localparam logic [REG_W-1:0] RG_PEND  = 4'd1;
  localparam logic [REG_W-1:0] RG_MASK  = 4'd2;
  localparam logic [REG_W-1:0] RG_MCLR  = 4'd3;
  localparam logic [REG_W-1:0] RG_MSET  = 4'd4;
  localparam logic [REG_W-1:0] RG_ROUTE = 4'd5;
  localparam logic [REG_W-1:0] RG_RSEL  = 4'd6;
  localparam logic [REG_W-1:0] RG_IDENT = 4'd7;
  localparam logic [REG_W-1:0] RG_CMPLO = 4'd8;
  localparam logic [REG_W-1:0] RG_CMPHI = 4'd9;
endpackage

// File: rtl/plb_decode.sv
module plb_decode
  import plb_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int PID_W    = 2
) (
  input  logic [PID_W-1:0]          req_id,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [NUM_PROC*PID_W-1:0] rsel_flat,
  output logic [PID_W-1:0]          tgt,
  output logic [REG_W-1:0]          reg_sel
);
  logic [PID_W-1:0] own_rsel;

  always_comb begin
    own_rsel = rsel_flat[req_id*PID_W +: PID_W];
    tgt      = req_addr[ADDR_W-1] ? own_rsel : req_id;
    reg_sel  = req_addr[REG_W-1:0];
  end
endmodule

// File: rtl/plb_bank.sv
module plb_bank
  import plb_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NPIN     = 6,
  parameter int PID_W    = 2,
  parameter int PIN_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmp_hit,
  output logic [MASK_W-1:0] mask_o,
  output logic [MASK_W-1:0] pend_o,
  output logic              flag_o,
  output logic [PIN_W-1:0]  pin_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [PID_W-1:0]  rsel_o,
  output logic [NPIN-1:0]   irq_vec_o
);
  localparam logic [RT_FIELD-1:0] MAX_PIN = RT_FIELD'(NPIN - 1);

  logic [MASK_W-1:0] mask_q, mask_d, pend_q, pend_d;
  logic              flag_q, flag_d;
  logic [PIN_W-1:0]  pin_q, pin_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic [PID_W-1:0]  rsel_q, rsel_d;
  logic              mask_ld, pend_ld, route_ld, cmp_ld, rsel_ld;
  logic              cmp_wr, cmp_line;

  always_comb begin
    mask_d   = mask_q;
    flag_d   = flag_q;
    pin_d    = pin_q;
    cmp_d    = cmp_q;
    rsel_d   = rsel_q;
    mask_ld  = 1'b0;
    route_ld = 1'b0;
    cmp_ld   = 1'b0;
    rsel_ld  = 1'b0;
    if (wr_en) begin
      case (reg_sel)
        RG_MSET: begin
          mask_d  = mask_q | wdata[MASK_W-1:0];
          mask_ld = 1'b1;
        end
        RG_MCLR: begin
          mask_d  = mask_q & ~wdata[MASK_W-1:0];
          mask_ld = 1'b1;
        end
        RG_ROUTE: begin
          flag_d   = wdata[RT_FLAG];
          pin_d    = wdata[PIN_W-1:0];
          route_ld = (wdata[RT_FIELD-1:0] <= MAX_PIN);
        end
        RG_RSEL: begin
          rsel_d  = wdata[PID_W-1:0];
          rsel_ld = (wdata < DATA_W'(NUM_PROC));
        end
        RG_CMPLO: begin
          cmp_d  = wdata;
          cmp_ld = 1'b1;
        end
        default: ;
      endcase
    end
    cmp_wr = wr_en && (reg_sel == RG_CMPLO);
    pend_d = pend_q;
    if (cmp_wr)  pend_d[CMP_BIT] = 1'b0;
    if (cmp_hit) pend_d[CMP_BIT] = 1'b1;
    pend_ld = cmp_wr | cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      pend_q <= '0;
      flag_q <= 1'b1;
      pin_q  <= '0;
      cmp_q  <= '1;
      rsel_q <= '0;
    end else begin
      if (mask_ld)  mask_q <= mask_d;
      if (pend_ld)  pend_q <= pend_d;
      if (route_ld) begin
        flag_q <= flag_d;
        pin_q  <= pin_d;
      end
      if (cmp_ld)   cmp_q  <= cmp_d;
      if (rsel_ld)  rsel_q <= rsel_d;
    end
  end

  always_comb begin
    cmp_line = pend_q[CMP_BIT] & mask_q[CMP_BIT] & flag_q;
    for (int p = 0; p < NPIN; p++) begin
      irq_vec_o[p] = cmp_line && (pin_q == PIN_W'(p));
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;
  assign cmp_o  = cmp_q;
  assign rsel_o = rsel_q;
endmodule

// File: rtl/plb_rdmux.sv
module plb_rdmux
  import plb_pkg::*;
#(
  parameter int PID_W = 2,
  parameter int PIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [PID_W-1:0]  tgt,
  input  logic [MASK_W-1:0] pend,
  input  logic [MASK_W-1:0] mask,
  input  logic              flag,
  input  logic [PIN_W-1:0]  pin,
  input  logic [DATA_W-1:0] cmp,
  input  logic [PID_W-1:0]  rsel,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              vld_q;

  always_comb begin
    case (reg_sel)
      RG_PEND:  rd_d = DATA_W'(pend);
      RG_MASK:  rd_d = DATA_W'(mask);
      RG_ROUTE: rd_d = {flag, (DATA_W-1-PIN_W)'(0), pin};
      RG_RSEL:  rd_d = DATA_W'(rsel);
      RG_IDENT: rd_d = DATA_W'(tgt);
      RG_CMPLO: rd_d = cmp;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/proc_local_bank.sv
module proc_local_bank
  import plb_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NPIN     = 6,
  localparam int PID_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int PIN_W   = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [PID_W-1:0]         req_id,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [NUM_PROC-1:0]      cmp_hit,
  input  logic [NUM_PROC*NPIN-1:0] shared_irq,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [NUM_PROC*NPIN-1:0] irq_out
);
  logic [NUM_PROC-1:0][MASK_W-1:0] mask_a, pend_a;
  logic [NUM_PROC-1:0]             flag_a;
  logic [NUM_PROC-1:0][PIN_W-1:0]  pin_a;
  logic [NUM_PROC-1:0][DATA_W-1:0] cmp_a;
  logic [NUM_PROC-1:0][PID_W-1:0]  rsel_a;
  logic [NUM_PROC-1:0][NPIN-1:0]   irqv_a;
  logic [NUM_PROC-1:0]             cmp_pend_v;
  logic [NUM_PROC*PID_W-1:0]       rsel_flat;
  logic [NUM_PROC*MASK_W-1:0]      mask_flat;
  logic [PID_W-1:0]                tgt_idx;
  logic [REG_W-1:0]                reg_sel;
  logic                            wr_any, rd_any;

  assign rsel_flat = rsel_a;
  assign mask_flat = mask_a;
  assign wr_any    = req_valid & req_write;
  assign rd_any    = req_valid & ~req_write;

  plb_decode #(.NUM_PROC(NUM_PROC), .PID_W(PID_W)) u_dec (
    .req_id(req_id), .req_addr(req_addr), .rsel_flat(rsel_flat),
    .tgt(tgt_idx), .reg_sel(reg_sel)
  );

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_bank
    plb_bank #(.NUM_PROC(NUM_PROC), .NPIN(NPIN), .PID_W(PID_W), .PIN_W(PIN_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_any && (tgt_idx == PID_W'(i))),
      .reg_sel(reg_sel), .wdata(req_wdata), .cmp_hit(cmp_hit[i]),
      .mask_o(mask_a[i]), .pend_o(pend_a[i]), .flag_o(flag_a[i]),
      .pin_o(pin_a[i]), .cmp_o(cmp_a[i]), .rsel_o(rsel_a[i]),
      .irq_vec_o(irqv_a[i])
    );
    assign cmp_pend_v[i]               = pend_a[i][CMP_BIT];
    assign irq_out[i*NPIN +: NPIN]     = shared_irq[i*NPIN +: NPIN] | irqv_a[i];
  end

  plb_rdmux #(.PID_W(PID_W), .PIN_W(PIN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_any), .reg_sel(reg_sel), .tgt(tgt_idx),
    .pend(pend_a[tgt_idx]), .mask(mask_a[tgt_idx]), .flag(flag_a[tgt_idx]),
    .pin(pin_a[tgt_idx]), .cmp(cmp_a[tgt_idx]), .rsel(rsel_a[tgt_idx]),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/plb_chk.sv
module plb_chk
  import plb_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NPIN     = 6,
  parameter int PID_W    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [NUM_PROC-1:0]       cmp_hit,
  input logic [NUM_PROC*NPIN-1:0]  shared_irq,
  input logic [NUM_PROC*NPIN-1:0]  irq_out,
  input logic                      rsp_valid,
  input logic [NUM_PROC-1:0]       cmp_pend_v,
  input logic [NUM_PROC*MASK_W-1:0] mask_flat,
  input logic [NUM_PROC*PID_W-1:0] rsel_flat,
  input logic [PID_W-1:0]          tgt_idx,
  input logic [REG_W-1:0]          reg_sel
);
  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r4_mask_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(mask_flat));
  a_r2_rsel_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(rsel_flat));
  a_r5_cmp_write_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && reg_sel == RG_CMPLO && !cmp_hit[tgt_idx])
      |=> !cmp_pend_v[$past(tgt_idx)]);

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_proc
    a_r6_hit_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> cmp_pend_v[i]);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      a_r7_shared_passes: assert property (@(posedge clk) disable iff (!rst_n)
        shared_irq[i*NPIN+p] |-> irq_out[i*NPIN+p]);
      a_r7_line_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out[i*NPIN+p] && !shared_irq[i*NPIN+p]) |-> cmp_pend_v[i]);
    end
  end
endmodule

bind proc_local_bank plb_chk #(.NUM_PROC(NUM_PROC), .NPIN(NPIN), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .cmp_hit(cmp_hit), .shared_irq(shared_irq), .irq_out(irq_out),
  .rsp_valid(rsp_valid), .cmp_pend_v(cmp_pend_v), .mask_flat(mask_flat),
  .rsel_flat(rsel_flat), .tgt_idx(tgt_idx), .reg_sel(reg_sel)
);

// File: tb/tb_proc_local_bank.sv
`timescale 1ns/1ps
module tb_proc_local_bank;
  localparam int NP = 4;
  localparam int NL = 6;
  localparam int IW = NP * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_id;
  logic [4:0]    req_addr;
  logic [31:0]   req_wdata;
  logic [NP-1:0] cmp_hit;
  logic [IW-1:0] shared_irq;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [IW-1:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  proc_local_bank #(.NUM_PROC(NP), .NPIN(NL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .cmp_hit(cmp_hit), .shared_irq(shared_irq), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  localparam logic NEAR = 1'b0;
  localparam logic FAR  = 1'b1;

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endfunction

  task automatic drive(input logic [1:0] id, input logic win, input logic [3:0] r,
                       input logic w, input logic [31:0] d, input logic [NP-1:0] hit);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_id = id;
    req_addr = {win, r}; req_wdata = d; cmp_hit = hit;
  endtask

  task automatic wr(input logic [1:0] id, input logic win, input logic [3:0] r,
                    input logic [31:0] d);
    drive(id, win, r, 1'b1, d, '0);
  endtask

  task automatic rd(input logic [1:0] id, input logic win, input logic [3:0] r,
                    input logic [31:0] exp, input string tag);
    drive(id, win, r, 1'b0, 32'h0, '0);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; cmp_hit = '0;
  endtask

  task automatic chk_irq(input logic [IW-1:0] exp, input string tag);
    n_cmp++;
    if (irq_out !== exp) begin
      n_bad++;
      $display("FAIL %s irq_out actual=%h expected=%h", tag, irq_out, exp);
    end
  endtask

  // Monitor: pops the scoreboard as read responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_cmp++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_id = '0;
    req_addr = '0; req_wdata = '0; cmp_hit = '0; shared_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset contents, R11 response path, R10 control reads 0
    chk_irq('0, "R9 lines low");
    rd(0, NEAR, 4'd0, 32'h0,         "R9/R10 ctrl");
    rd(0, NEAR, 4'd1, 32'h0,         "R9 pending");
    rd(0, NEAR, 4'd2, 32'h32,        "R9 mask");
    rd(0, NEAR, 4'd5, 32'h8000_0000, "R9 route");
    rd(0, NEAR, 4'd6, 32'h0,         "R9 rsel");
    rd(0, NEAR, 4'd8, 32'hFFFF_FFFF, "R9 compare");
    rd(0, NEAR, 4'd9, 32'h0,         "R5 compare upper");

    // R3 identity, R1 far window
    rd(2, NEAR, 4'd7, 32'd2, "R3 near ident");
    wr(2, NEAR, 4'd6, 32'd3);
    rd(2, FAR,  4'd7, 32'd3, "R1 far ident");
    wr(2, FAR,  4'd8, 32'h0000_1234);
    rd(3, NEAR, 4'd8, 32'h0000_1234, "R1 far write lands in bank 3");
    rd(2, NEAR, 4'd8, 32'hFFFF_FFFF, "R1 own bank untouched");

    // R2 remote-select range
    wr(2, NEAR, 4'd6, 32'd4);
    rd(2, NEAR, 4'd6, 32'd3, "R2 value 4 ignored");
    wr(2, NEAR, 4'd6, 32'hFFFF_0001);
    rd(2, NEAR, 4'd6, 32'd3, "R2 wide value ignored");
    wr(2, NEAR, 4'd6, 32'd1);
    rd(2, NEAR, 4'd6, 32'd1, "R2 value 1 accepted");

    // R4 mask set/clear
    wr(1, NEAR, 4'd3, 32'hFFFF_FFFF);
    rd(1, NEAR, 4'd2, 32'h00, "R4 clear all");
    wr(1, NEAR, 4'd4, 32'hFFFF_FFC2);
    rd(1, NEAR, 4'd2, 32'h02, "R4 set drops high bits");
    wr(1, NEAR, 4'd4, 32'h10);
    rd(1, NEAR, 4'd2, 32'h12, "R4 set ORs");
    wr(1, NEAR, 4'd3, 32'h02);
    rd(1, NEAR, 4'd2, 32'h10, "R4 clear selected");
    wr(1, NEAR, 4'd2, 32'h3F);
    rd(1, NEAR, 4'd2, 32'h10, "R4 direct mask write ignored");
    wr(1, NEAR, 4'd4, 32'h02);

    // R8 route legality
    wr(1, NEAR, 4'd5, 32'h8000_0006);
    rd(1, NEAR, 4'd5, 32'h8000_0000, "R8 pin 6 ignored");
    wr(1, NEAR, 4'd5, 32'h8000_0005);
    rd(1, NEAR, 4'd5, 32'h8000_0005, "R8 pin 5 accepted");
    wr(1, NEAR, 4'd5, 32'h8000_003F);
    rd(1, NEAR, 4'd5, 32'h8000_0005, "R8 pin 63 ignored");
    wr(1, NEAR, 4'd5, 32'h0000_0003);
    rd(1, NEAR, 4'd5, 32'h0000_0003, "R8 flag clear");
    wr(1, NEAR, 4'd5, 32'h8000_0004);

    // R6 / R7 compare strobe on proc 1, routed to line 4
    drive(0, NEAR, 4'd0, 1'b0, 32'h0, 4'b0010);
    q_exp.push_back(32'h0); q_tag.push_back("R10 ctrl read");
    idle();
    chk_irq(IW'(1) << 10, "R7 compare line raised");
    rd(1, NEAR, 4'd1, 32'h02, "R6 pending set");
    wr(1, NEAR, 4'd3, 32'h02);
    idle();
    chk_irq('0, "R7 mask gates line");
    rd(1, NEAR, 4'd1, 32'h02, "R7 pending kept while masked");
    wr(1, NEAR, 4'd4, 32'h02);
    wr(1, NEAR, 4'd5, 32'h0000_0004);
    idle();
    chk_irq('0, "R7 route flag gates line");
    wr(1, NEAR, 4'd5, 32'h8000_0004);
    idle();
    chk_irq(IW'(1) << 10, "R7 line back");

    // R5 compare write acknowledges
    wr(1, NEAR, 4'd8, 32'h55);
    idle();
    chk_irq('0, "R5 ack drops line");
    rd(1, NEAR, 4'd1, 32'h0,  "R5 pending cleared");
    rd(1, NEAR, 4'd8, 32'h55, "R5 compare stored");
    rd(1, NEAR, 4'd9, 32'h0,  "R5 upper half");

    // R6 collision: strobe with compare write, same bank
    drive(1, NEAR, 4'd8, 1'b1, 32'h66, 4'b0010);
    idle();
    chk_irq(IW'(1) << 10, "R6 collision keeps line");
    rd(1, NEAR, 4'd1, 32'h02, "R6 collision pending");
    rd(1, NEAR, 4'd8, 32'h66, "R6 collision value stored");

    // R7 shared OR
    shared_irq = IW'(1) << 18;
    idle();
    chk_irq((IW'(1) << 18) | (IW'(1) << 10), "R7 shared plus compare");
    shared_irq = (IW'(1) << 18) | (IW'(1) << 10);
    wr(1, NEAR, 4'd8, 32'h77);
    idle();
    chk_irq((IW'(1) << 18) | (IW'(1) << 10), "R7 shared holds acked line");
    shared_irq = '0;
    idle();
    chk_irq('0, "R7 all sources gone");

    // R10 control and unknown offsets
    wr(3, NEAR, 4'd0, 32'hFFFF_FFFF);
    rd(3, NEAR, 4'd0, 32'h0, "R10 ctrl write ignored");
    rd(3, NEAR, 4'd15, 32'h0, "R10 near unknown offset");
    rd(0, FAR,  4'd12, 32'h0, "R10 far unknown offset");

    repeat (4) idle();
    n_cmp++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R11 missing responses actual=%0d expected=0", q_exp.size());
    end
    summary();
    $finish;
  end
endmodule